// File: doc/BRIEF.md
# Vectored Interrupt Controller with Spurious-Read Detection

This block collects a set of interrupt sources and raises two active-low request lines toward a processor. The first request line is normal and is resolved by priority. The second is fast and is fed by exactly one source. Source 0 is the fast source and has its own pin. Sources 2 and up are normal sources with pins. Source 1 is a software-only normal source and has no pin. Each source has its own trigger mode and its own handler vector, set by software. Every pin passes through a two-flop synchronizer. In an edge mode, an edge sets a sticky pending latch. In a level mode, pending follows the synchronized input.

The processor acknowledges a normal interrupt by reading the IRQ vector register. That read returns the vector of the winning source and marks the source in service. The normal request line then stays high until software writes end-of-interrupt. A vector read can find nothing valid. This happens when a level source has dropped, when a source was disabled at the moment it fired, or when the read simply comes with nothing pending. In that case the read returns a programmable spurious vector. Both request lines then stay high until end-of-interrupt is written.

Register access uses a small request/response bus. The request channel is valid/ready, and ready is always high, so there is never back-pressure and every request is taken in the cycle it is offered. Every accepted read returns exactly one response, one cycle later, on a valid strobe that cannot be stalled. Writes produce no response.

Top module: `vic_top`

## Requirements
- R1: After reset, both request lines are high, the enable mask is zero, `rsp_valid` is low, and the pending register reads zero while all pins are low. Every mode register resets to high level, priority 0.
- R2: `reg_ready` is always 1. A read accepted in one cycle gives `rsp_valid`=1 with its data in the next cycle, and a write gives no response. The word addresses are:
  - 0x00+i: mode register of source i. Bits [1:0] hold the trigger and bits [6:4] hold the priority; all other bits read 0.
  - 0x20+i: vector register of source i.
  - 0x40: IRQ vector.
  - 0x41: fast vector.
  - 0x42: pending.
  - 0x43: mask.
  - 0x44: enable command.
  - 0x45: disable command.
  - 0x46: set command.
  - 0x47: clear command.
  - 0x48: end-of-interrupt.
  - 0x49: spurious vector.
- R3: The trigger codes are 00 low level, 01 falling edge, 10 high level and 11 rising edge. An edge found after two synchronizer stages sets a latch that stays set. A level source's pending bit follows the synchronized pin.
- R4: A write of ones to the enable command sets mask bits, and a write of ones to the disable command clears them. `nirq` is low while some enabled source from 1 upward is pending, none is in service, and no spurious condition is open.
- R5: A read of the IRQ vector returns the vector of the enabled pending source with the highest priority, and the lowest index wins a tie. The read clears that source's edge latch, marks it in service, and holds `nirq` high until end-of-interrupt.
- R6: For an edge-mode source, a set-command bit forces it pending and a clear-command bit clears it. For a level-mode source, both commands have no effect.
- R7: The pin of source 1 has no effect. That source becomes pending only through the set command while it is in an edge mode.
- R8: `nfiq` is low while source 0 is enabled and pending, and no priority logic or in-service state affects it. Reading the fast vector returns source 0's vector and clears its edge latch.
- R9: A read of the IRQ vector with no enabled source from 1 upward pending, or a read of the fast vector with source 0 not enabled and pending, returns the spurious vector. This covers a level source that has already dropped and a source disabled just before the read.
- R10: After a spurious read, `nirq` and `nfiq` both stay high, even with sources pending, until end-of-interrupt is written.
- R11: A write to end-of-interrupt clears the in-service mark and the spurious condition, so pending sources drive the request lines again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Source pins: bit 0 is the fast source, and bit 1 has no effect |
| reg_valid | input | 1 | Register request valid |
| reg_ready | output | 1 | Register request ready (always 1) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| nirq | output | 1 | Normal request, active low |
| nfiq | output | 1 | Fast request, active low |

## Verification
The bench builds the block with NSRC = 6. This gives one fast source, the software source, and four pin sources. That is enough to hold two equal-priority edge sources next to a higher-numbered level source, so the tie rule and the ordering of the acknowledge sequence are both exercised. The small width also keeps every pending and mask value short enough to predict by hand. A behavioural model runs beside the block and is compared on both request lines and on every response, while the directed cases cover the level-drop and disable races that lead to spurious reads.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int PRIO_W = 3;
  localparam int MAX_SRC = 32;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_FALL = 2'b01,
    TRG_HIGH = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;

  localparam logic [AW-1:0] A_MODE = 8'h00;
  localparam logic [AW-1:0] A_VEC  = 8'h20;
  localparam logic [AW-1:0] A_IVR  = 8'h40;
  localparam logic [AW-1:0] A_FVR  = 8'h41;
  localparam logic [AW-1:0] A_PEND = 8'h42;
  localparam logic [AW-1:0] A_MASK = 8'h43;
  localparam logic [AW-1:0] A_EN   = 8'h44;
  localparam logic [AW-1:0] A_DIS  = 8'h45;
  localparam logic [AW-1:0] A_SET  = 8'h46;
  localparam logic [AW-1:0] A_CLR  = 8'h47;
  localparam logic [AW-1:0] A_EOI  = 8'h48;
  localparam logic [AW-1:0] A_SPUR = 8'h49;
endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond #(
  parameter bit SOFT_ONLY = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] trig_i,
  input  logic       set_i,
  input  logic       clr_i,
  input  logic       ack_i,
  output logic       pend_o
);
  logic s1_q, s2_q, prv_q, lat_q;
  logic pin_g, edge_mode, edge_hit, lvl_hit;

  // the software source never sees its pin
  assign pin_g = SOFT_ONLY ? 1'b0 : pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      prv_q <= 1'b0;
    end else begin
      s1_q  <= pin_g;
      s2_q  <= s1_q;
      prv_q <= s2_q;
    end
  end

  assign edge_mode = trig_i[0];
  assign edge_hit  = trig_i[1] ? (s2_q & ~prv_q) : (~s2_q & prv_q);
  assign lvl_hit   = SOFT_ONLY ? 1'b0 : (s2_q == trig_i[1]);

  // new edge or forced set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lat_q <= 1'b0;
    else if (!edge_mode)          lat_q <= 1'b0;
    else if (edge_hit || set_i)   lat_q <= 1'b1;
    else if (clr_i || ack_i)      lat_q <= 1'b0;
  end

  assign pend_o = edge_mode ? lat_q : lvl_hit;

  AST_SET_FORCES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && set_i) |=> pend_o);  // R6
  AST_LEVEL_KEEPS_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && set_i) |=> !lat_q);  // R6
  AST_CLEAR_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr_i && !edge_hit && !set_i) |=> !lat_q);  // R6
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic [PW-1:0] best;

  // strict greater-than keeps the lowest index on a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i*PW +: PW] > best)) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
        best    = prio_i[i*PW +: PW];
      end
    end
  end

  AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[idx_o]);  // R5
  AST_NONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (req_i == '0));  // R9

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      AST_NO_BETTER_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && req_i[g]) |-> (prio_i[g*PW +: PW] <= best));  // R5
      AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && req_i[g] && (prio_i[g*PW +: PW] == best)) |-> (IW'(g) >= idx_o));  // R5
    end
  endgenerate
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            reg_valid,
  output logic            reg_ready,
  input  logic            reg_write,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            nirq,
  output logic            nfiq
);
  logic [1:0]        trig_q [NSRC];
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [DW-1:0]     vec_q  [NSRC];
  logic [DW-1:0]     spur_vec_q;
  logic [NSRC-1:0]   mask_q;
  logic              in_svc_q, spur_q;
  logic              rsp_valid_q;
  logic [DW-1:0]     rsp_data_q;

  logic              wr, rd;
  logic              in_mode, in_vec;
  logic [IW-1:0]     sel;
  logic [NSRC-1:0]   set_cmd, clr_cmd, ack_vec, pend, active, irq_req;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic              win_valid;
  logic [IW-1:0]     win_idx;
  logic              ivr_rd, fvr_rd, eoi_wr;
  logic              irq_ok, fiq_ok;
  logic [DW-1:0]     rd_val;

  assign reg_ready = 1'b1;
  assign wr = reg_valid && reg_write;
  assign rd = reg_valid && !reg_write;

  assign in_mode = (reg_addr[7:5] == A_MODE[7:5]) && (32'(reg_addr[4:0]) < NSRC);
  assign in_vec  = (reg_addr[7:5] == A_VEC[7:5])  && (32'(reg_addr[4:0]) < NSRC);
  assign sel     = reg_addr[IW-1:0];

  assign ivr_rd = rd && (reg_addr == A_IVR);
  assign fvr_rd = rd && (reg_addr == A_FVR);
  assign eoi_wr = wr && (reg_addr == A_EOI);

  assign set_cmd = (wr && reg_addr == A_SET) ? reg_wdata[NSRC-1:0] : '0;
  assign clr_cmd = (wr && reg_addr == A_CLR) ? reg_wdata[NSRC-1:0] : '0;

  // per-source conditioning; index 1 is the pinless software source
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      vic_src_cond #(.SOFT_ONLY(g == 1)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (src_in[g]),
        .trig_i (trig_q[g]),
        .set_i  (set_cmd[g]),
        .clr_i  (clr_cmd[g]),
        .ack_i  (ack_vec[g]),
        .pend_o (pend[g])
      );
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
  endgenerate

  assign active  = pend & mask_q;
  assign irq_req = {active[NSRC-1:1], 1'b0};

  vic_prio #(.N(NSRC), .PW(PRIO_W)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (irq_req),
    .prio_i  (prio_flat),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  assign irq_ok = win_valid && !spur_q;
  assign fiq_ok = active[0] && !spur_q;

  always_comb begin
    ack_vec = '0;
    if (ivr_rd && irq_ok) ack_vec[win_idx] = 1'b1;
    if (fvr_rd && fiq_ok) ack_vec[0] = 1'b1;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        trig_q[i] <= TRG_HIGH;
        prio_q[i] <= '0;
        vec_q[i]  <= '0;
      end
      spur_vec_q <= '0;
      mask_q     <= '0;
    end else if (wr) begin
      if (in_mode) begin
        trig_q[sel] <= reg_wdata[1:0];
        prio_q[sel] <= reg_wdata[6:4];
      end
      if (in_vec) vec_q[sel] <= reg_wdata;
      if (reg_addr == A_EN)   mask_q <= mask_q | reg_wdata[NSRC-1:0];
      if (reg_addr == A_DIS)  mask_q <= mask_q & ~reg_wdata[NSRC-1:0];
      if (reg_addr == A_SPUR) spur_vec_q <= reg_wdata;
    end
  end

  // acknowledge state: one active level plus the spurious lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q <= 1'b0;
      spur_q   <= 1'b0;
    end else if (eoi_wr) begin
      in_svc_q <= 1'b0;
      spur_q   <= 1'b0;
    end else begin
      if (ivr_rd && irq_ok) in_svc_q <= 1'b1;
      if ((ivr_rd && !irq_ok) || (fvr_rd && !fiq_ok)) spur_q <= 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_mode) rd_val = {{(DW-7){1'b0}}, prio_q[sel], 2'b00, trig_q[sel]};
    else if (in_vec) rd_val = vec_q[sel];
    else begin
      case (reg_addr)
        A_IVR:   rd_val = irq_ok ? vec_q[win_idx] : spur_vec_q;
        A_FVR:   rd_val = fiq_ok ? vec_q[0] : spur_vec_q;
        A_PEND:  rd_val = DW'(pend);
        A_MASK:  rd_val = DW'(mask_q);
        A_SPUR:  rd_val = spur_vec_q;
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd;
      if (rd) rsp_data_q <= rd_val;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign nirq = ~(win_valid && !in_svc_q && !spur_q);
  assign nfiq = ~(active[0] && !spur_q);

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);  // R2
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !rsp_valid);  // R2
  AST_ACK_RELEASES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ivr_rd && irq_ok) |=> nirq);  // R5
  AST_SPUR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    ((ivr_rd && !irq_ok) || (fvr_rd && !fiq_ok)) |=> (nirq && nfiq));  // R10
  AST_SPUR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_q && !eoi_wr) |=> spur_q);  // R10
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> (!spur_q && !in_svc_q));  // R11
  AST_FIQ_FOLLOWS_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
    !nfiq |-> (mask_q[0] && pend[0]));  // R8
endmodule

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  localparam int N = 6;
  localparam logic [7:0] A_MODE = 8'h00, A_VEC = 8'h20, A_IVR = 8'h40, A_FVR = 8'h41,
    A_PEND = 8'h42, A_MASK = 8'h43, A_EN = 8'h44, A_DIS = 8'h45, A_SET = 8'h46,
    A_CLR = 8'h47, A_EOI = 8'h48, A_SPUR = 8'h49;
  localparam logic [31:0] SPV = 32'hDEAD_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_ready, rsp_valid, nirq, nfiq;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  bit live = 1'b0;

  vic_top #(.NSRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .nirq(nirq), .nfiq(nfiq));

  always #2.5 clk = ~clk;

  // behavioural reference
  logic [1:0] m_trig [N];
  int m_prio [N];
  logic [31:0] m_vec [N];
  logic [31:0] m_spv;
  bit m_mask [N], m_s1 [N], m_s2 [N], m_prv [N], m_lat [N];
  bit m_svc, m_spur, m_rv;
  logic [31:0] m_rd;

  function automatic bit m_pend(int i);
    if (m_trig[i][0]) return m_lat[i];
    if (i == 1) return 1'b0;
    return m_s2[i] == m_trig[i][1];
  endfunction

  function automatic int m_win();
    int w = -1;
    for (int i = 1; i < N; i++)
      if (m_pend(i) && m_mask[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
    return w;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_trig[i] = 2'b10; m_prio[i] = 0; m_vec[i] = '0; m_mask[i] = 0;
      m_s1[i] = 0; m_s2[i] = 0; m_prv[i] = 0; m_lat[i] = 0;
    end
    m_spv = '0; m_svc = 0; m_spur = 0; m_rv = 0; m_rd = '0;
  endtask

  task automatic m_step();
    bit pd [N];
    bit nl [N];
    int w, si;
    bit irq_ok, fiq_ok, rd, wr, hit, st, cl, ak;
    logic [31:0] v;
    for (int i = 0; i < N; i++) pd[i] = m_pend(i);
    w = m_win();
    irq_ok = (w >= 0) && !m_spur;
    fiq_ok = pd[0] && m_mask[0] && !m_spur;
    rd = reg_valid && !reg_write;
    wr = reg_valid && reg_write;
    si = int'(reg_addr[4:0]);
    if (rd) begin
      v = '0;
      if (reg_addr[7:5] == 3'd0 && si < N) v = {25'd0, 3'(m_prio[si]), 2'b00, m_trig[si]};
      else if (reg_addr[7:5] == 3'd1 && si < N) v = m_vec[si];
      else if (reg_addr == A_IVR) v = irq_ok ? m_vec[w] : m_spv;
      else if (reg_addr == A_FVR) v = fiq_ok ? m_vec[0] : m_spv;
      else if (reg_addr == A_PEND) begin for (int i = 0; i < N; i++) v[i] = pd[i]; end
      else if (reg_addr == A_MASK) begin for (int i = 0; i < N; i++) v[i] = m_mask[i]; end
      else if (reg_addr == A_SPUR) v = m_spv;
      m_rd = v;
    end
    m_rv = rd;
    for (int i = 0; i < N; i++) begin
      hit = m_trig[i][1] ? (m_s2[i] && !m_prv[i]) : (!m_s2[i] && m_prv[i]);
      st = wr && reg_addr == A_SET && reg_wdata[i];
      cl = wr && reg_addr == A_CLR && reg_wdata[i];
      ak = (rd && reg_addr == A_IVR && irq_ok && w == i) || (rd && reg_addr == A_FVR && fiq_ok && i == 0);
      if (!m_trig[i][0]) nl[i] = 0;
      else if (hit || st) nl[i] = 1;
      else if (cl || ak) nl[i] = 0;
      else nl[i] = m_lat[i];
    end
    if (wr && reg_addr == A_EOI) begin m_svc = 0; m_spur = 0; end
    else begin
      if (rd && reg_addr == A_IVR) begin if (irq_ok) m_svc = 1; else m_spur = 1; end
      if (rd && reg_addr == A_FVR && !fiq_ok) m_spur = 1;
    end
    if (wr) begin
      if (reg_addr[7:5] == 3'd0 && si < N) begin m_trig[si] = reg_wdata[1:0]; m_prio[si] = int'(reg_wdata[6:4]); end
      if (reg_addr[7:5] == 3'd1 && si < N) m_vec[si] = reg_wdata;
      for (int i = 0; i < N; i++) begin
        if (reg_addr == A_EN && reg_wdata[i]) m_mask[i] = 1;
        if (reg_addr == A_DIS && reg_wdata[i]) m_mask[i] = 0;
      end
      if (reg_addr == A_SPUR) m_spv = reg_wdata;
    end
    for (int i = 0; i < N; i++) begin
      m_lat[i] = nl[i];
      m_prv[i] = m_s2[i];
      m_s2[i] = m_s1[i];
      m_s1[i] = (i == 1) ? 1'b0 : src_in[i];
    end
  endtask

  initial m_reset();
  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R4 nirq vs model", 32'(nirq), 32'(!(m_win() >= 0 && !m_svc && !m_spur)));
      chk("R8 nfiq vs model", 32'(nfiq), 32'(!(m_pend(0) && m_mask[0] && !m_spur)));
      chk("R2 rsp_valid vs model", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk("R2 rsp_data vs model", rsp_data, m_rd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(posedge clk); #1;
    reg_valid = 0;
    d = rsp_data;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    tick(3);
    rst_n = 1;
    tick(1);
    live = 1;
    chk("R1 nirq idle", 32'(nirq), 1);
    chk("R1 nfiq idle", 32'(nfiq), 1);
    chk("R1 rsp_valid idle", 32'(rsp_valid), 0);
    rd(A_PEND, d); chk("R1 pending zero", d, 0);
    rd(A_MASK, d); chk("R1 mask zero", d, 0);
    rd(A_MODE + 8'd4, d); chk("R1 mode reset high level", d, 32'h2);
    chk("R2 ready high", 32'(reg_ready), 1);

    for (int i = 0; i < N; i++) wr(A_VEC + 8'(i), 32'hA000_0000 + i);
    wr(A_SPUR, SPV);
    rd(A_VEC + 8'd3, d); chk("R2 vector readback", d, 32'hA000_0003);
    rd(A_SPUR, d); chk("R2 spurious readback", d, SPV);

    // level source
    wr(A_MODE + 8'd2, 32'h22);
    rd(A_MODE + 8'd2, d); chk("R2 mode readback", d, 32'h22);
    wr(A_EN, 32'h4);
    rd(A_MASK, d); chk("R4 mask after enable", d, 32'h4);
    src_in[2] = 1; tick(3);
    chk("R4 nirq asserted", 32'(nirq), 0);
    rd(A_PEND, d); chk("R3 level pending", d, 32'h4);
    rd(A_IVR, d); chk("R5 vector of level source", d, 32'hA000_0002);
    chk("R5 nirq released in service", 32'(nirq), 1);
    src_in[2] = 0; tick(3);
    rd(A_PEND, d); chk("R3 level follows pin", d, 0);
    wr(A_EOI, 0);

    // priority and tie
    wr(A_MODE + 8'd3, 32'h53);
    wr(A_MODE + 8'd4, 32'h53);
    wr(A_MODE + 8'd5, 32'h12);
    wr(A_EN, 32'h38);
    src_in[3] = 1; src_in[4] = 1; src_in[5] = 1; tick(2);
    src_in[3] = 0; src_in[4] = 0; tick(4);
    rd(A_PEND, d); chk("R3 edge latches sticky", d, 32'h38);
    rd(A_IVR, d); chk("R5 tie lowest index", d, 32'hA000_0003);
    wr(A_EOI, 0);
    chk("R11 eoi reasserts nirq", 32'(nirq), 0);
    rd(A_IVR, d); chk("R5 next by priority", d, 32'hA000_0004);
    wr(A_EOI, 0);
    rd(A_IVR, d); chk("R5 lowest priority last", d, 32'hA000_0005);
    src_in[5] = 0; tick(3);
    wr(A_EOI, 0);
    chk("R5 nothing left", 32'(nirq), 1);

    // set and clear commands
    wr(A_SET, 32'h8);
    rd(A_PEND, d); chk("R6 set forces edge source", d, 32'h8);
    wr(A_CLR, 32'h8);
    rd(A_PEND, d); chk("R6 clear drops edge source", d, 0);
    wr(A_SET, 32'h4);
    rd(A_PEND, d); chk("R6 set ignored in level mode", d, 0);

    // software source
    wr(A_MODE + 8'd1, 32'h13);
    wr(A_EN, 32'h2);
    src_in[1] = 1; tick(4);
    rd(A_PEND, d); chk("R7 pin of software source ignored", d, 0);
    src_in[1] = 0;
    wr(A_SET, 32'h2);
    rd(A_IVR, d); chk("R7 software source vector", d, 32'hA000_0001);
    wr(A_EOI, 0);

    // fast source
    wr(A_MODE + 8'd0, 32'h01);
    wr(A_EN, 32'h1);
    src_in[0] = 1; tick(3);
    chk("R8 no falling edge yet", 32'(nfiq), 1);
    src_in[0] = 0; tick(4);
    chk("R8 nfiq asserted", 32'(nfiq), 0);
    chk("R8 nirq unaffected", 32'(nirq), 1);
    rd(A_FVR, d); chk("R8 fast vector", d, 32'hA000_0000);
    chk("R8 fast latch cleared", 32'(nfiq), 1);

    // spurious handling
    rd(A_IVR, d); chk("R9 empty read spurious", d, SPV);
    src_in[2] = 1; tick(3);
    chk("R10 nirq held high", 32'(nirq), 1);
    src_in[0] = 1; tick(2); src_in[0] = 0; tick(4);
    chk("R10 nfiq held high", 32'(nfiq), 1);
    wr(A_EOI, 0);
    chk("R11 nirq back", 32'(nirq), 0);
    chk("R11 nfiq back", 32'(nfiq), 0);
    rd(A_FVR, d); chk("R8 fast vector after eoi", d, 32'hA000_0000);
    rd(A_IVR, d); chk("R5 level vector after eoi", d, 32'hA000_0002);
    src_in[2] = 0; tick(4);
    wr(A_EOI, 0);

    src_in[2] = 1; tick(3);
    chk("R4 level asserts", 32'(nirq), 0);
    src_in[2] = 0; tick(3);
    rd(A_IVR, d); chk("R9 level dropped before read", d, SPV);
    wr(A_EOI, 0);

    wr(A_SET, 32'h8);
    chk("R4 forced source asserts", 32'(nirq), 0);
    wr(A_DIS, 32'h8);
    rd(A_MASK, d); chk("R4 mask after disable", d, 32'h37);
    rd(A_IVR, d); chk("R9 disabled before read", d, SPV);
    wr(A_EOI, 0);
    wr(A_CLR, 32'h8);

    rd(A_FVR, d); chk("R9 fast read spurious", d, SPV);
    chk("R10 both lines high", 32'({nirq, nfiq}), 32'h3);
    wr(A_EOI, 0);
    tick(3);

    live = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule